// File: doc/BRIEF.md
# Inclusive Shared-Cache Directory Controller

This block is the coherence engine for one slice of an inclusive shared cache. Each entry in its small set-associative tag array carries a writable-owner flag, a dirty flag, a data token and a tracking vector with one bit per private cache. Private caches talk to it through one request stream. The stream carries reads, writes, clean and dirty eviction notices, and acknowledgments. The block answers on one message stream. Its answer is a grant to the requester, a forward to the single writable owner, a multicast invalidation or recall, or an eviction acknowledgment. The tracking vector is kept exact because every private eviction, clean or dirty, is announced and acknowledged.

A miss allocates a way. The block takes a free way first, then a way that no core tracks. Only when every way of the set is tracked does it issue a recall. A recall or an invalidation keeps the controller busy until all acknowledgments have arrived. During that time only acknowledgments are accepted. The backing memory is a fixed-latency responder. It returns the block address, zero-extended, as the data token, and it keeps no written-back values.

Both streams use valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` depends on `req_type` and on the controller state, so a sender must hold every request field stable while `req_valid` is high. An outgoing message stays valid, with every field unchanged, until a clock edge where `msg_ready` is high. The controller accepts no new request while a message is pending.

Top module: `dirc_dir_ctrl`

## Requirements
- R1: After reset no message is pending and `req_ready` is high.
- R2: A read miss (type 0) or write miss (type 1) fetches from memory with a fixed latency. It then sends grant-read (code 0) or grant-write (code 1) to the requester only. The grant carries the block address as its data token.
- R3: A read hit is answered with grant-read carrying the stored token, unless another core owns the block writable. The requester is added to the tracking vector. A write hit with no other tracked core gets grant-write directly.
- R4: A read of a block owned writable by another core sends one forward (code 2) to that owner only, with the requester's id in `msg_core`. Afterwards both cores are tracked and the block is no longer owned.
- R5: A write to a block tracked by other cores sends one invalidation (code 3) to exactly those cores, never to the requester. Grant-write follows only after every acknowledgment (type 4) has arrived. The requester then becomes the sole tracked owner.
- R6: While invalidation or recall acknowledgments are outstanding, requests of types 0 to 3 are not accepted.
- R7: Every eviction notice, clean (type 2) or dirty (type 3), is answered with an eviction acknowledgment (code 5) to its sender. The sender's tracking bit is cleared.
- R8: The data of a dirty eviction notice becomes the entry's token. The data carried by the owner's invalidation acknowledgment also becomes the entry's token. Later grants carry that token.
- R9: A miss takes the lowest-numbered invalid way. Failing that it takes the lowest-numbered valid way with an empty tracking vector. Failing that it takes the way named by a rotating pointer, which advances by one (modulo the way count) on each such pick.
- R10: A victim with tracked cores gets a recall (code 4) to exactly those cores, carrying the victim's address. The fill starts only after all recall acknowledgments (type 5) have arrived.
- R11: A pending message keeps valid and all its fields stable until `msg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request accepted this edge |
| req_type | input | 3 | 0 read, 1 write, 2 clean evict, 3 dirty evict, 4 inval ack, 5 recall ack |
| req_core | input | CW | sending core |
| req_addr | input | AW | block address, low bits select the set |
| req_data | input | DW | token for dirty evict and inval ack |
| msg_valid | output | 1 | message present |
| msg_ready | input | 1 | message taken this edge |
| msg_type | output | 3 | 0 grant-read, 1 grant-write, 2 forward, 3 invalidate, 4 recall, 5 evict ack |
| msg_dest | output | CORES | destination mask |
| msg_core | output | CW | requester id |
| msg_addr | output | AW | block address |
| msg_data | output | DW | data token |

## Verification
The bench uses four cores, four sets, two ways and a memory latency of three. With only two ways, a handful of addresses that share one set drives the block through free-way fills, unshared-way replacement and pointer-chosen recalls. Four cores make multi-target invalidations, forwards and mixed clean and dirty evictions common. Random message back-pressure exercises the hold rule of the output stream.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [2:0] {
    RQ_READ = 3'd0, RQ_WRITE = 3'd1, RQ_CLEAN_EV = 3'd2,
    RQ_DIRTY_EV = 3'd3, RQ_INV_ACK = 3'd4, RQ_RCL_ACK = 3'd5
  } rq_kind_e;

  typedef enum logic [2:0] {
    MS_GRANT_RD = 3'd0, MS_GRANT_WR = 3'd1, MS_FWD_RD = 3'd2,
    MS_INVAL = 3'd3, MS_RECALL = 3'd4, MS_EV_ACK = 3'd5
  } ms_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_FILL, ST_GRANT
  } ctl_state_e;
endpackage

// File: rtl/dirc_tag_store.sv
module dirc_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int CORES = 4,
  parameter int TW    = 6,
  parameter int DW    = 16,
  localparam int SW   = $clog2(SETS),
  localparam int WW   = $clog2(WAYS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SW-1:0]                   rd_set,
  output logic [WAYS-1:0]                 rd_valid,
  output logic [WAYS-1:0]                 rd_own,
  output logic [WAYS-1:0]                 rd_dirty,
  output logic [WAYS-1:0][TW-1:0]         rd_tag,
  output logic [WAYS-1:0][CORES-1:0]      rd_shr,
  output logic [WAYS-1:0][DW-1:0]         rd_data,
  input  logic                            we,
  input  logic [SW-1:0]                   w_set,
  input  logic [WW-1:0]                   w_way,
  input  logic                            w_valid,
  input  logic                            w_own,
  input  logic                            w_dirty,
  input  logic [TW-1:0]                   w_tag,
  input  logic [CORES-1:0]                w_shr,
  input  logic [DW-1:0]                   w_data
);
  logic             valid_q [SETS][WAYS];
  logic             own_q   [SETS][WAYS];
  logic [CORES-1:0] shr_q   [SETS][WAYS];
  logic             dirty_q [SETS][WAYS];
  logic [TW-1:0]    tag_q   [SETS][WAYS];
  logic [DW-1:0]    data_q  [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          own_q[s][w]   <= 1'b0;
          shr_q[s][w]   <= '0;
        end
    end else if (we) begin
      valid_q[w_set][w_way] <= w_valid;
      own_q[w_set][w_way]   <= w_own;
      shr_q[w_set][w_way]   <= w_shr;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      dirty_q[w_set][w_way] <= w_dirty;
      tag_q[w_set][w_way]   <= w_tag;
      data_q[w_set][w_way]  <= w_data;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_valid[w] = valid_q[rd_set][w];
    assign rd_own[w]   = own_q[rd_set][w];
    assign rd_dirty[w] = dirty_q[rd_set][w];
    assign rd_tag[w]   = tag_q[rd_set][w];
    assign rd_shr[w]   = shr_q[rd_set][w];
    assign rd_data[w]  = data_q[rd_set][w];
  end
endmodule

// File: rtl/dirc_way_select.sv
module dirc_way_select #(
  parameter int WAYS  = 2,
  parameter int CORES = 4,
  parameter int TW    = 6,
  localparam int WW   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TW-1:0]    tag,
  input  logic [WAYS-1:0][CORES-1:0] shr,
  input  logic [TW-1:0]              lk_tag,
  input  logic [WW-1:0]              ptr,
  output logic                       hit,
  output logic [WW-1:0]              hit_way,
  output logic [WW-1:0]              vic_way
);
  logic          has_free, has_clean;
  logic [WW-1:0] free_way, clean_way;

  always_comb begin
    hit = 1'b0; hit_way = '0;
    has_free = 1'b0; free_way = '0;
    has_clean = 1'b0; clean_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid[w] && tag[w] == lk_tag) begin
        hit = 1'b1; hit_way = WW'(w);
      end
      if (!valid[w]) begin
        has_free = 1'b1; free_way = WW'(w);
      end
      if (valid[w] && shr[w] == '0) begin
        has_clean = 1'b1; clean_way = WW'(w);
      end
    end
    vic_way = has_free ? free_way : (has_clean ? clean_way : ptr);
  end
endmodule

// File: rtl/dirc_mem_model.sv
module dirc_mem_model #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int LAT = 3,
  localparam int LW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          done,
  output logic [DW-1:0] data
);
  logic [LW-1:0] cnt_q;

  assign done = req && (cnt_q == LW'(LAT - 1));
  assign data = DW'(addr);

  always_ff @(posedge clk) begin
    if (!rst_n || !req || done) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dirc_dir_ctrl.sv
module dirc_dir_ctrl
  import dirc_pkg::*;
#(
  parameter int CORES   = 4,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int MEM_LAT = 3,
  localparam int CW     = $clog2(CORES),
  localparam int SW     = $clog2(SETS),
  localparam int TW     = AW - SW,
  localparam int WW     = $clog2(WAYS),
  localparam int NW     = $clog2(CORES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_type,
  input  logic [CW-1:0]    req_core,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [2:0]       msg_type,
  output logic [CORES-1:0] msg_dest,
  output logic [CW-1:0]    msg_core,
  output logic [AW-1:0]    msg_addr,
  output logic [DW-1:0]    msg_data
);
  function automatic logic [NW-1:0] pop(input logic [CORES-1:0] v);
    pop = '0;
    for (int i = 0; i < CORES; i++) pop = pop + NW'(v[i]);
  endfunction

  ctl_state_e       st_q, st_d, after_q, after_d;
  logic [2:0]       p_type_q, p_type_d;
  logic [CW-1:0]    p_core_q, p_core_d;
  logic [SW-1:0]    p_set_q, p_set_d;
  logic [TW-1:0]    p_tag_q, p_tag_d;
  logic [WW-1:0]    p_way_q, p_way_d, ptr_q, ptr_d;
  logic             p_miss_q, p_miss_d;
  logic [NW-1:0]    cnt_q, cnt_d;
  logic [2:0]       m_type_q, m_type_d;
  logic [CORES-1:0] m_dest_q, m_dest_d;
  logic [CW-1:0]    m_core_q, m_core_d;
  logic [AW-1:0]    m_addr_q, m_addr_d;
  logic [DW-1:0]    m_data_q, m_data_d;

  logic                       idle, req_is_ack, accept;
  logic [SW-1:0]              rd_set;
  logic [TW-1:0]              lk_tag;
  logic [WAYS-1:0]            rd_valid, rd_own, rd_dirty;
  logic [WAYS-1:0][TW-1:0]    rd_tag;
  logic [WAYS-1:0][CORES-1:0] rd_shr;
  logic [WAYS-1:0][DW-1:0]    rd_data;
  logic                       hit;
  logic [WW-1:0]              hit_way, vic_way, cw;
  logic [CORES-1:0]           req_bit, p_bit, e_shr;
  logic                       e_own;
  logic [DW-1:0]              e_data;
  logic                       we, w_valid, w_own, w_dirty;
  logic [TW-1:0]              w_tag;
  logic [CORES-1:0]           w_shr;
  logic [DW-1:0]              w_data;
  logic                       mem_req, mem_done;
  logic [DW-1:0]              mem_data;

  assign idle       = (st_q == ST_IDLE);
  assign req_is_ack = (req_type == RQ_INV_ACK) || (req_type == RQ_RCL_ACK);
  assign req_ready  = idle || (st_q == ST_WAIT && req_is_ack);
  assign accept     = req_valid && req_ready;
  assign rd_set     = idle ? req_addr[SW-1:0] : p_set_q;
  assign lk_tag     = idle ? req_addr[AW-1:SW] : p_tag_q;
  assign cw         = idle ? hit_way : p_way_q;
  assign e_shr      = rd_shr[cw];
  assign e_own      = rd_own[cw];
  assign e_data     = rd_data[cw];
  assign req_bit    = CORES'(1) << req_core;
  assign p_bit      = CORES'(1) << p_core_q;
  assign mem_req    = (st_q == ST_FILL);

  dirc_tag_store #(.SETS(SETS), .WAYS(WAYS), .CORES(CORES), .TW(TW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(rd_set),
    .rd_valid(rd_valid), .rd_own(rd_own), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .rd_shr(rd_shr), .rd_data(rd_data),
    .we(we), .w_set(rd_set), .w_way(cw), .w_valid(w_valid), .w_own(w_own),
    .w_dirty(w_dirty), .w_tag(w_tag), .w_shr(w_shr), .w_data(w_data));

  dirc_way_select #(.WAYS(WAYS), .CORES(CORES), .TW(TW)) u_sel (
    .valid(rd_valid), .tag(rd_tag), .shr(rd_shr), .lk_tag(lk_tag), .ptr(ptr_q),
    .hit(hit), .hit_way(hit_way), .vic_way(vic_way));

  dirc_mem_model #(.AW(AW), .DW(DW), .LAT(MEM_LAT)) u_mem (
    .clk(clk), .rst_n(rst_n), .req(mem_req), .addr({p_tag_q, p_set_q}),
    .done(mem_done), .data(mem_data));

  always_comb begin
    st_d = st_q; after_d = after_q;
    p_type_d = p_type_q; p_core_d = p_core_q; p_set_d = p_set_q; p_tag_d = p_tag_q;
    p_way_d = p_way_q; p_miss_d = p_miss_q; cnt_d = cnt_q; ptr_d = ptr_q;
    m_type_d = m_type_q; m_dest_d = m_dest_q; m_core_d = m_core_q;
    m_addr_d = m_addr_q; m_data_d = m_data_q;
    we = 1'b0; w_valid = 1'b1; w_own = e_own; w_dirty = rd_dirty[cw];
    w_tag = rd_tag[cw]; w_shr = e_shr; w_data = e_data;
    unique case (st_q)
      ST_IDLE: if (accept && !req_is_ack) begin
        p_type_d = req_type; p_core_d = req_core; p_set_d = rd_set; p_tag_d = lk_tag;
        m_core_d = req_core; m_addr_d = req_addr; m_dest_d = req_bit; m_data_d = e_data;
        if (req_type == RQ_CLEAN_EV || req_type == RQ_DIRTY_EV) begin
          if (hit) begin
            we = 1'b1;
            w_shr = e_shr & ~req_bit;
            w_own = e_own && ((e_shr & req_bit) == '0);
            if (req_type == RQ_DIRTY_EV) begin
              w_data = req_data; w_dirty = 1'b1;
            end
          end
          m_type_d = MS_EV_ACK; st_d = ST_SEND; after_d = ST_IDLE;
        end else if (hit) begin
          p_way_d = hit_way; p_miss_d = 1'b0;
          if (req_type == RQ_READ && e_own && (e_shr & req_bit) == '0) begin
            we = 1'b1; w_shr = e_shr | req_bit; w_own = 1'b0;
            m_type_d = MS_FWD_RD; m_dest_d = e_shr; st_d = ST_SEND; after_d = ST_IDLE;
          end else if (req_type == RQ_WRITE && (e_shr & ~req_bit) != '0) begin
            m_type_d = MS_INVAL; m_dest_d = e_shr & ~req_bit; cnt_d = pop(e_shr & ~req_bit);
            st_d = ST_SEND; after_d = ST_WAIT;
          end else begin
            st_d = ST_GRANT;
          end
        end else begin
          p_way_d = vic_way; p_miss_d = 1'b1;
          if (rd_valid[vic_way] && rd_shr[vic_way] != '0) begin
            m_type_d = MS_RECALL; m_dest_d = rd_shr[vic_way];
            m_addr_d = {rd_tag[vic_way], rd_set}; cnt_d = pop(rd_shr[vic_way]);
            ptr_d = (ptr_q == WW'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
            st_d = ST_SEND; after_d = ST_WAIT;
          end else begin
            st_d = ST_FILL;
          end
        end
      end
      ST_SEND: if (msg_ready) st_d = after_q;
      ST_WAIT: if (accept) begin
        cnt_d = cnt_q - 1'b1;
        if (req_type == RQ_INV_ACK && e_own) begin
          we = 1'b1; w_data = req_data; w_dirty = 1'b1;
        end
        if (cnt_q == NW'(1)) st_d = p_miss_q ? ST_FILL : ST_GRANT;
      end
      ST_FILL: if (mem_done) begin
        we = 1'b1; w_tag = p_tag_q; w_own = 1'b0; w_shr = '0;
        w_dirty = 1'b0; w_data = mem_data; st_d = ST_GRANT;
      end
      ST_GRANT: begin
        we = 1'b1; m_dest_d = p_bit; m_core_d = p_core_q; m_data_d = e_data;
        m_addr_d = {p_tag_q, p_set_q};
        if (p_type_q == RQ_WRITE) begin
          w_shr = p_bit; w_own = 1'b1; m_type_d = MS_GRANT_WR;
        end else begin
          w_shr = e_shr | p_bit; m_type_d = MS_GRANT_RD;
        end
        st_d = ST_SEND; after_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; after_q <= ST_IDLE;
      p_type_q <= '0; p_core_q <= '0; p_set_q <= '0; p_tag_q <= '0;
      p_way_q <= '0; p_miss_q <= 1'b0; cnt_q <= '0; ptr_q <= '0;
      m_type_q <= '0; m_dest_q <= '0; m_core_q <= '0; m_addr_q <= '0; m_data_q <= '0;
    end else begin
      st_q <= st_d; after_q <= after_d;
      p_type_q <= p_type_d; p_core_q <= p_core_d; p_set_q <= p_set_d; p_tag_q <= p_tag_d;
      p_way_q <= p_way_d; p_miss_q <= p_miss_d; cnt_q <= cnt_d; ptr_q <= ptr_d;
      m_type_q <= m_type_d; m_dest_q <= m_dest_d; m_core_q <= m_core_d;
      m_addr_q <= m_addr_d; m_data_q <= m_data_d;
    end
  end

  assign msg_valid = (st_q == ST_SEND);
  assign msg_type  = m_type_q;
  assign msg_dest  = m_dest_q;
  assign msg_core  = m_core_q;
  assign msg_addr  = m_addr_q;
  assign msg_data  = m_data_q;
endmodule

// File: rtl/dirc_dir_ctrl_chk.sv
module dirc_dir_ctrl_chk #(
  parameter int CORES = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int CW   = $clog2(CORES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [2:0]       msg_type,
  input logic [CORES-1:0] msg_dest,
  input logic [CW-1:0]    msg_core,
  input logic [AW-1:0]    msg_addr,
  input logic [DW-1:0]    msg_data
);
  p_msg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_type) && $stable(msg_dest)
      && $stable(msg_core) && $stable(msg_addr) && $stable(msg_data));

  p_grant_to_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type <= 3'd1 |-> msg_dest == (CORES'(1) << msg_core));

  p_fwd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd2 |-> $countones(msg_dest) == 1
      && (msg_dest & (CORES'(1) << msg_core)) == '0);

  p_inval_others_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd3 |-> msg_dest != '0
      && (msg_dest & (CORES'(1) << msg_core)) == '0);

  p_busy_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);

  p_evack_sender_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd5 |-> msg_dest == (CORES'(1) << msg_core));

  p_recall_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd4 |-> msg_dest != '0);
endmodule

bind dirc_dir_ctrl dirc_dir_ctrl_chk #(.CORES(CORES), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_type(msg_type), .msg_dest(msg_dest),
  .msg_core(msg_core), .msg_addr(msg_addr), .msg_data(msg_data));

// File: tb/dirc_dir_ctrl_tb.sv
module dirc_dir_ctrl_tb;
  localparam int CORES = 4, SETS = 4, WAYS = 2, AW = 8, DW = 16, LAT = 3;
  localparam int CW = $clog2(CORES), SW = $clog2(SETS), TW = AW - SW;
  localparam time PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, msg_ready = 1'b0;
  logic req_ready, msg_valid;
  logic [2:0] req_type = '0, msg_type;
  logic [CW-1:0] req_core = '0, msg_core;
  logic [AW-1:0] req_addr = '0, msg_addr;
  logic [DW-1:0] req_data = '0, msg_data;
  logic [CORES-1:0] msg_dest;

  int vectors = 0, misses = 0;
  bit done = 1'b0;

  bit               mv [SETS][WAYS];
  logic [TW-1:0]    mt [SETS][WAYS];
  bit               mown [SETS][WAYS];
  logic [CORES-1:0] ms [SETS][WAYS];
  logic [DW-1:0]    md [SETS][WAYS];
  int mptr = 0;

  always #(PERIOD/2) clk = ~clk;

  dirc_dir_ctrl #(.CORES(CORES), .SETS(SETS), .WAYS(WAYS), .AW(AW), .DW(DW), .MEM_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_core(req_core), .req_addr(req_addr), .req_data(req_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type), .msg_dest(msg_dest),
    .msg_core(msg_core), .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [2:0] t, input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_core = CW'(c); req_addr = a; req_data = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic get_msg(output logic [2:0] ty, output logic [CORES-1:0] de,
                         output logic [CW-1:0] co, output logic [AW-1:0] ad, output logic [DW-1:0] da);
    bit stalled = 1'b0;
    logic [2:0] sty; logic [CORES-1:0] sde; logic [AW-1:0] sad; logic [DW-1:0] sda;
    forever begin
      @(negedge clk);
      msg_ready = ($urandom % 3) != 0;
      #1;
      if (stalled) begin
        chk("R11", "held type", {29'd0, msg_type}, {29'd0, sty});
        chk("R11", "held dest", 32'(msg_dest), 32'(sde));
        chk("R11", "held addr/data", {msg_addr, msg_data}, {sad, sda});
        stalled = 1'b0;
      end
      if (msg_valid && msg_ready) begin
        ty = msg_type; de = msg_dest; co = msg_core; ad = msg_addr; da = msg_data;
        @(posedge clk); #1;
        msg_ready = 1'b0;
        return;
      end else if (msg_valid) begin
        stalled = 1'b1; sty = msg_type; sde = msg_dest; sad = msg_addr; sda = msg_data;
      end
    end
  endtask

  task automatic expect_msg(input string tag, input logic [2:0] ety, input logic [CORES-1:0] ede,
                            input int eco, input logic [AW-1:0] ead, input bit cdata, input logic [DW-1:0] eda);
    logic [2:0] ty; logic [CORES-1:0] de; logic [CW-1:0] co; logic [AW-1:0] ad; logic [DW-1:0] da;
    get_msg(ty, de, co, ad, da);
    chk(tag, "type", {29'd0, ty}, {29'd0, ety});
    chk(tag, "dest", 32'(de), 32'(ede));
    if (eco >= 0) chk(tag, "core", 32'(co), 32'(eco));
    chk(tag, "addr", 32'(ad), 32'(ead));
    if (cdata) chk(tag, "data", 32'(da), 32'(eda));
  endtask

  task automatic send_acks(input logic [2:0] t, input logic [CORES-1:0] mask, input logic [DW-1:0] d);
    for (int i = 0; i < CORES; i++) if (mask[i]) send_req(t, i, '0, d);
  endtask

  task automatic transact(input logic [2:0] t, input int c, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit probe);
    int s = int'(a[SW-1:0]);
    logic [TW-1:0] g = a[AW-1:SW];
    logic [CORES-1:0] bitc = CORES'(1) << c;
    int w = -1;
    for (int i = WAYS - 1; i >= 0; i--) if (mv[s][i] && mt[s][i] == g) w = i;
    send_req(t, c, a, d);
    if (t >= 3'd2) begin
      expect_msg("R7", 3'd5, bitc, c, a, 1'b0, '0);
      if (w >= 0) begin
        if (ms[s][w] & bitc) mown[s][w] = 1'b0;
        ms[s][w] &= ~bitc;
        if (t == 3'd3) md[s][w] = d;
      end
      return;
    end
    if (w >= 0 && t == 3'd0 && mown[s][w] && (ms[s][w] & bitc) == '0) begin
      expect_msg("R4", 3'd2, ms[s][w], c, a, 1'b0, '0);
      ms[s][w] |= bitc; mown[s][w] = 1'b0;
      return;
    end
    if (w >= 0 && t == 3'd1 && (ms[s][w] & ~bitc) != '0) begin
      logic [DW-1:0] ackd = DW'($urandom);
      expect_msg("R5", 3'd3, ms[s][w] & ~bitc, c, a, 1'b0, '0);
      if (probe) begin
        @(negedge clk);
        req_valid = 1'b1; req_type = 3'd0; req_core = CW'((c + 1) % CORES); req_addr = a + 8'd4;
        for (int k = 0; k < 3; k++) begin
          #1; chk("R6", "ready while acks owed", 32'(req_ready), 32'd0);
          @(negedge clk);
        end
        req_valid = 1'b0;
      end
      send_acks(3'd4, ms[s][w] & ~bitc, ackd);
      if (mown[s][w]) md[s][w] = ackd;
    end else if (w < 0) begin
      for (int i = WAYS - 1; i >= 0; i--) if (!mv[s][i]) w = i;
      if (w < 0) for (int i = WAYS - 1; i >= 0; i--) if (ms[s][i] == '0) w = i;
      if (w < 0) begin
        w = mptr;
        mptr = (mptr + 1) % WAYS;
        expect_msg("R10", 3'd4, ms[s][w], -1, {mt[s][w], SW'(s)}, 1'b0, '0);
        send_acks(3'd5, ms[s][w], '0);
      end
      mv[s][w] = 1'b1; mt[s][w] = g; md[s][w] = DW'(a); ms[s][w] = '0; mown[s][w] = 1'b0;
    end
    if (t == 3'd1) begin
      expect_msg("R2/R3/R5/R8", 3'd1, bitc, c, a, 1'b1, md[s][w]);
      ms[s][w] = bitc; mown[s][w] = 1'b1;
    end else begin
      expect_msg("R2/R3/R8", 3'd0, bitc, c, a, 1'b1, md[s][w]);
      ms[s][w] |= bitc;
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 1'b0; ms[s][w] = '0; mown[s][w] = 1'b0; mt[s][w] = '0; md[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "msg_valid after reset", 32'(msg_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "msg_valid idle", 32'(msg_valid), 32'd0);

    // directed: R2 cold miss, R3 shared hit, R5/R6 invalidation, R4 forward
    transact(3'd0, 0, 8'h04, '0, 1'b0);
    transact(3'd0, 1, 8'h04, '0, 1'b0);
    transact(3'd1, 2, 8'h04, '0, 1'b1);
    transact(3'd0, 3, 8'h04, '0, 1'b0);
    // R7/R8: dirty notice, then read returns written data
    transact(3'd3, 2, 8'h04, 16'hBEEF, 1'b0);
    transact(3'd0, 0, 8'h04, '0, 1'b0);
    transact(3'd2, 0, 8'h04, '0, 1'b0);
    transact(3'd2, 3, 8'h04, '0, 1'b0);
    // R9/R10: free way, unshared way, then pointer recall
    transact(3'd0, 1, 8'h08, '0, 1'b0);
    transact(3'd0, 1, 8'h0C, '0, 1'b0);
    transact(3'd0, 2, 8'h10, '0, 1'b0);
    transact(3'd1, 3, 8'h14, '0, 1'b0);

    for (int n = 0; n < 600; n++) begin
      int c = int'($urandom % CORES);
      int r = int'($urandom % 10);
      logic [AW-1:0] a = {TW'($urandom % 5), SW'($urandom % SETS)};
      bit evd = 1'b0;
      if (r < 3) begin
        int s0 = int'($urandom % SETS);
        for (int k = 0; k < SETS * WAYS && !evd; k++) begin
          int s = (s0 + k / WAYS) % SETS;
          int w = k % WAYS;
          if (mv[s][w] && ms[s][w][c]) begin
            transact(mown[s][w] ? 3'd3 : 3'd2, c, {mt[s][w], SW'(s)}, DW'($urandom), 1'b0);
            evd = 1'b1;
          end
        end
      end
      if (!evd) transact((r < 7) ? 3'd0 : 3'd1, c, a, '0, 1'b0);
    end
    done = 1'b1;
    report();
  end
endmodule